// File: doc/BRIEF.md
# Width-Aware Shared Multiplier Chain

This block evaluates y = (a·a)·(b·c) for three signed 16-bit operands on one shared 32×32 signed multiplier. Two narrow products are formed first: the square of a and the cross product of b and c. Each product is sign-extended to 32 bits, fed to the shared multiplier and written to its own intermediate register. The two intermediates are then multiplied together into a signed 64-bit result. The result is wide enough to hold every product exactly.

The controller does not reserve the multiplier for the worst case on every use. It gives each operation a number of cycles that depends on the operand width that operation actually uses. That count is the register-to-register path delay rounded up to whole clock periods. The path is two 2-to-1 operand multiplexers, the multiplier, and the register set-up. With the default timing figures, each narrow product takes one cycle and the wide product takes two. One job therefore spans four cycles, not six.

A user pulses `start` with the operands valid. The block samples the operands on that edge. It raises `done` for one cycle together with the new `y`, and `y` then holds until the next job completes. A `start` that arrives while a job is in flight is dropped.

Top module: `wa_mulchain`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `y` reads 0 and `done` reads 0.
- R2: The result equals the exact signed 64-bit value (a·a)·(b·c), in two's complement. The operands are the values present on the edge where `start` was accepted.
- R3: `done` is high for exactly one cycle. It rises 4 clock edges after the edge that accepted `start`, and `y` carries the new result in that same cycle.
- R4: A `start` sampled on any of the 4 edges after an accepted `start` is ignored. It neither restarts nor lengthens the job, and no extra `done` follows.
- R5: Changes on `a`, `b` and `c` after the accepting edge have no effect on the job in flight.
- R6: Boundary operands give exact results. For example, with a = b = c = -32768 the result is 2^60, and a zero operand gives 0.
- R7: Each 16-bit product holds the multiplier for one cycle and the 32-bit product holds it for two. The operand selects stay unchanged through the two cycles of the wide product. Together these give the latency of 1 + 1 + 2 cycles.
- R8: `y` keeps its value until the next `done`. A `start` sampled on the edge right after the `done` cycle is accepted, so jobs can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Job request, sampled only when idle |
| a | input | 16 | Signed operand that is squared |
| b | input | 16 | Signed operand of the cross product |
| c | input | 16 | Signed operand of the cross product |
| y | output | 64 | Signed result (a·a)·(b·c) |
| done | output | 1 | One-cycle pulse marking a new result on `y` |

## Verification
On every cycle, the assertions check four things. `done` is a single-cycle pulse that arrives exactly the job latency after an accepted request. The operand registers are frozen while the block is busy. The multiplier selects stay steady through the non-final cycles of a multicycle product. `y` moves only in a `done` cycle, and it then equals the exact product of the latched operands. Only the bench scenarios can show behaviour seen from outside: the arithmetic at the signed extremes, the dropping of requests and operand changes that arrive mid-job, back-to-back acceptance right after `done`, and the reset values.

// File: rtl/wa_mul_pkg.sv
package wa_mul_pkg;

    localparam int IN_W   = 16;
    localparam int MUL_W  = 2 * IN_W;
    localparam int PROD_W = 2 * MUL_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SQ   = 2'd1,
        PH_XP   = 2'd2,
        PH_FIN  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SEL_SQUARE = 2'd0,
        SEL_CROSS  = 2'd1,
        SEL_FINAL  = 2'd2
    } opsel_e;

    typedef struct packed {
        logic signed [IN_W-1:0] a;
        logic signed [IN_W-1:0] b;
        logic signed [IN_W-1:0] c;
    } opnd_s;

    typedef struct packed {
        logic signed [MUL_W-1:0] x;
        logic signed [MUL_W-1:0] y;
    } mpair_s;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // cycles = ceil(path / period); path = two muxes + operator + register set-up,
    // scaled by a routing margin in percent
    function automatic int op_cycles(input int width, input int ps_per_bit,
                                     input int mux_ps, input int reg_ps,
                                     input int route_pct, input int clk_ps);
        int path;
        path = ps_per_bit * width + 2 * mux_ps + reg_ps;
        path = ceil_div(path * (100 + route_pct), 100);
        return (path < clk_ps) ? 1 : ceil_div(path, clk_ps);
    endfunction

    function automatic int cnt_width(input int max_cycles);
        return (max_cycles > 2) ? $clog2(max_cycles) : 1;
    endfunction

endpackage

// File: rtl/wa_opnd_bank.sv
module wa_opnd_bank
    import wa_mul_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic signed [IN_W-1:0] a,
    input  logic signed [IN_W-1:0] b,
    input  logic signed [IN_W-1:0] c,
    output opnd_s                  opnd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            opnd <= '0;
        end else if (load) begin
            opnd.a <= a;
            opnd.b <= b;
            opnd.c <= c;
        end
    end
endmodule

// File: rtl/wa_opnd_sel.sv
module wa_opnd_sel
    import wa_mul_pkg::*;
(
    input  opsel_e                  sel,
    input  opnd_s                   opnd,
    input  logic signed [MUL_W-1:0] t_val,
    input  logic signed [MUL_W-1:0] q_val,
    output mpair_s                  pair
);
    logic signed [MUL_W-1:0] ext_a, ext_b, ext_c;
    logic signed [MUL_W-1:0] x_stage1, y_stage1;

    // sign extension keeps the low product bits exact after one narrow pass
    assign ext_a = MUL_W'(opnd.a);
    assign ext_b = MUL_W'(opnd.b);
    assign ext_c = MUL_W'(opnd.c);

    // first 2:1 level picks the narrow operand set
    assign x_stage1 = (sel == SEL_CROSS) ? ext_b : ext_a;
    assign y_stage1 = (sel == SEL_CROSS) ? ext_c : ext_a;

    // second 2:1 level swaps in the intermediate products
    assign pair.x = (sel == SEL_FINAL) ? t_val : x_stage1;
    assign pair.y = (sel == SEL_FINAL) ? q_val : y_stage1;
endmodule

// File: rtl/wa_shared_mult.sv
module wa_shared_mult
    import wa_mul_pkg::*;
(
    input  mpair_s                   pair,
    output logic signed [PROD_W-1:0] prod
);
    logic signed [PROD_W-1:0] xe, ye;

    assign xe   = PROD_W'(pair.x);
    assign ye   = PROD_W'(pair.y);
    assign prod = xe * ye;
endmodule

// File: rtl/wa_seq_ctrl.sv
module wa_seq_ctrl
    import wa_mul_pkg::*;
#(
    parameter int NARROW_CYC = 1,
    parameter int WIDE_CYC   = 2,
    parameter int HOLD_W     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              load_opnd,
    output logic              cap_t,
    output logic              cap_q,
    output logic              cap_y,
    output logic              busy,
    output opsel_e            sel,
    output phase_e            phase,
    output logic [HOLD_W-1:0] hold
);
    localparam logic [HOLD_W-1:0] NARROW_LAST = HOLD_W'(NARROW_CYC - 1);
    localparam logic [HOLD_W-1:0] WIDE_LAST   = HOLD_W'(WIDE_CYC - 1);

    logic last_cyc;

    assign busy      = (phase != PH_IDLE);
    assign last_cyc  = (hold == '0);
    assign load_opnd = !busy && start;
    assign cap_t     = (phase == PH_SQ)  && last_cyc;
    assign cap_q     = (phase == PH_XP)  && last_cyc;
    assign cap_y     = (phase == PH_FIN) && last_cyc;

    always_comb begin
        unique case (phase)
            PH_XP:   sel = SEL_CROSS;
            PH_FIN:  sel = SEL_FINAL;
            default: sel = SEL_SQUARE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            hold  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_SQ;
                    hold  <= NARROW_LAST;
                end
                PH_SQ: if (last_cyc) begin
                    phase <= PH_XP;
                    hold  <= NARROW_LAST;
                end else begin
                    hold <= hold - 1'b1;
                end
                PH_XP: if (last_cyc) begin
                    phase <= PH_FIN;
                    hold  <= WIDE_LAST;
                end else begin
                    hold <= hold - 1'b1;
                end
                PH_FIN: if (last_cyc) begin
                    phase <= PH_IDLE;
                end else begin
                    hold <= hold - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wa_mulchain.sv
module wa_mulchain
    import wa_mul_pkg::*;
#(
    parameter int CLK_PS     = 5000,
    parameter int MUX_PS     = 300,
    parameter int REG_PS     = 200,
    parameter int PS_PER_BIT = 250,
    parameter int ROUTE_PCT  = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [IN_W-1:0]   a,
    input  logic signed [IN_W-1:0]   b,
    input  logic signed [IN_W-1:0]   c,
    output logic signed [PROD_W-1:0] y,
    output logic                     done
);
    localparam int NARROW_CYC = op_cycles(IN_W,  PS_PER_BIT, MUX_PS, REG_PS, ROUTE_PCT, CLK_PS);
    localparam int WIDE_CYC   = op_cycles(MUL_W, PS_PER_BIT, MUX_PS, REG_PS, ROUTE_PCT, CLK_PS);
    localparam int MAX_CYC    = (WIDE_CYC > NARROW_CYC) ? WIDE_CYC : NARROW_CYC;
    localparam int HOLD_W     = cnt_width(MAX_CYC);
    localparam int LATENCY    = 2 * NARROW_CYC + WIDE_CYC;

    logic                     load_w, cap_t_w, cap_q_w, cap_y_w, busy_w;
    opsel_e                   sel_w;
    phase_e                   phase_w;
    logic [HOLD_W-1:0]        hold_w;
    opnd_s                    opnd_w;
    mpair_s                   pair_w;
    logic signed [PROD_W-1:0] prod_w;
    logic signed [MUL_W-1:0]  t_q, q_q;

    wa_seq_ctrl #(
        .NARROW_CYC (NARROW_CYC),
        .WIDE_CYC   (WIDE_CYC),
        .HOLD_W     (HOLD_W)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load_opnd (load_w),
        .cap_t     (cap_t_w),
        .cap_q     (cap_q_w),
        .cap_y     (cap_y_w),
        .busy      (busy_w),
        .sel       (sel_w),
        .phase     (phase_w),
        .hold      (hold_w)
    );

    wa_opnd_bank i_bank (
        .clk  (clk),
        .rst  (rst),
        .load (load_w),
        .a    (a),
        .b    (b),
        .c    (c),
        .opnd (opnd_w)
    );

    wa_opnd_sel i_sel (
        .sel   (sel_w),
        .opnd  (opnd_w),
        .t_val (t_q),
        .q_val (q_q),
        .pair  (pair_w)
    );

    wa_shared_mult i_mult (
        .pair (pair_w),
        .prod (prod_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q  <= '0;
            q_q  <= '0;
            y    <= '0;
            done <= 1'b0;
        end else begin
            if (cap_t_w) t_q <= prod_w[MUL_W-1:0];
            if (cap_q_w) q_q <= prod_w[MUL_W-1:0];
            if (cap_y_w) y   <= prod_w;
            done <= cap_y_w;
        end
    end
endmodule

// File: rtl/wa_mulchain_chk.sv
module wa_mulchain_chk
    import wa_mul_pkg::*;
#(
    parameter int LAT    = 4,
    parameter int HOLD_W = 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     done,
    input logic                     busy,
    input logic signed [PROD_W-1:0] y,
    input opnd_s                    opnd,
    input phase_e                   phase,
    input logic [HOLD_W-1:0]        hold,
    input opsel_e                   sel
);
    localparam int CW = $clog2(LAT + 1) + 1;

    logic [CW-1:0]            age;
    logic signed [PROD_W-1:0] ea, eb, ec, expect_y;

    always_ff @(posedge clk) begin
        if (rst)                 age <= '0;
        else if (start && !busy) age <= CW'(1);
        else if (age == CW'(LAT)) age <= '0;
        else if (age != '0)      age <= age + 1'b1;
    end

    assign ea       = PROD_W'(opnd.a);
    assign eb       = PROD_W'(opnd.b);
    assign ec       = PROD_W'(opnd.c);
    assign expect_y = (ea * ea) * (eb * ec);

    // R3: done arrives exactly LAT edges after acceptance
    a_r3_done_on_time: assert property (@(posedge clk) disable iff (rst)
        (age == CW'(LAT)) |=> done);
    a_r3_done_only_on_time: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(age == CW'(LAT)));
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R4: the block stays busy for the whole job window
    a_r4_busy_window: assert property (@(posedge clk) disable iff (rst)
        (age != '0 && age != CW'(LAT)) |-> busy);
    // R5: latched operands cannot move while a job is running
    a_r5_opnd_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(opnd));
    // R7: selects held through the non-final cycles of a multicycle product
    a_r7_sel_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && hold != '0) |=> ($stable(sel) && $stable(phase)));
    // R8: y moves only in a done cycle
    a_r8_y_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(y));

    // R2: the published result matches the latched operands
    always @(posedge clk) begin
        if (!rst && done) begin
            a_r2_result: assert (y == expect_y);
        end
    end
endmodule

bind wa_mulchain wa_mulchain_chk #(
    .LAT    (LATENCY),
    .HOLD_W (HOLD_W)
) i_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .done  (done),
    .busy  (busy_w),
    .y     (y),
    .opnd  (opnd_w),
    .phase (phase_w),
    .hold  (hold_w),
    .sel   (sel_w)
);

// File: tb/test_wa_mulchain.sv
`timescale 1ns/1ps
module test_wa_mulchain;

    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic signed [15:0] a, b, c;
    logic signed [63:0] y;
    logic               done;

    int n_tests = 0;
    int n_fail  = 0;

    wa_mulchain i_wa_mulchain (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .a     (a),
        .b     (b),
        .c     (c),
        .y     (y),
        .done  (done)
    );

    always #5 clk = ~clk;

    function automatic longint ref_y(input logic signed [15:0] ra, rb, rc);
        longint ta, tb, tc;
        ta = ra; tb = rb; tc = rc;
        return (ta * ta) * (tb * tc);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one job; glitch_at: edge (1..4) on which a busy start with junk operands
    // is presented; scramble: change operands every cycle after acceptance
    task automatic run_job(input logic signed [15:0] ja, jb, jc,
                           input int glitch_at, input bit scramble, input string req);
        longint exp_v;
        exp_v = ref_y(ja, jb, jc);
        start = 1'b1; a = ja; b = jb; c = jc;
        @(posedge clk);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            start = (glitch_at == k);
            if (scramble || glitch_at == k) begin
                a = 16'($urandom()); b = 16'($urandom()); c = 16'($urandom());
            end
            if (k < 4) check(done == 1'b0, {req, " R3 no early done"}, done, 0);
            @(posedge clk);
        end
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, {req, " R3/R7 done after 4 edges"}, done, 1);
        check(y == exp_v, {req, " R2 result"}, y, exp_v);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; a = '0; b = '0; c = '0;
        repeat (3) @(negedge clk);
        check(y == 0 && done == 0, "R1 during reset", y, 0);
        rst = 1'b0;
        @(negedge clk);
        check(y == 0 && done == 0, "R1 after reset", y, 0);
    endtask

    task automatic t_basic();
        run_job(16'sd3, 16'sd5, -16'sd7, 0, 0, "basic");
        run_job(16'sd1234, -16'sd321, 16'sd77, 0, 0, "basic2");
        @(negedge clk);
        check(done == 1'b0, "R3 done one cycle", done, 0);
    endtask

    task automatic t_extremes();
        run_job(-16'sd32768, -16'sd32768, -16'sd32768, 0, 0, "R6 min^4");
        check(y == 64'sh1000_0000_0000_0000, "R6 2^60", y, 64'sh1000_0000_0000_0000);
        run_job(16'sd32767, 16'sd32767, 16'sd32767, 0, 0, "R6 max");
        run_job(-16'sd32768, 16'sd32767, -16'sd32768, 0, 0, "R6 mixed");
        run_job(-16'sd32768, 16'sd32767, 16'sd32767, 0, 0, "R6 negative");
        run_job(16'sd0, 16'sd32767, -16'sd32768, 0, 0, "R6 zero a");
        check(y == 0, "R6 zero result", y, 0);
        run_job(-16'sd1, -16'sd1, 16'sd1, 0, 0, "R6 minus one");
    endtask

    task automatic t_random();
        for (int i = 0; i < 20; i++)
            run_job(16'($urandom()), 16'($urandom()), 16'($urandom()), 0, 0, "R2 random");
    endtask

    task automatic t_busy_start();
        for (int g = 1; g <= 4; g++) begin
            run_job(16'sd200 + 16'(g), -16'sd99, 16'sd4321, g, 0, "R4 busy start");
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check(done == 1'b0, "R4 no second done", done, 0);
            end
        end
    endtask

    task automatic t_input_change();
        run_job(-16'sd5000, 16'sd30000, -16'sd2, 0, 1, "R5 inputs moved");
    endtask

    task automatic t_back_to_back();
        longint keep;
        run_job(16'sd11, 16'sd12, 16'sd13, 0, 0, "R8 first");
        run_job(-16'sd21, 16'sd22, -16'sd23, 0, 0, "R8 back to back");
        keep = y;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a = 16'($urandom()); b = 16'($urandom()); c = 16'($urandom());
            check(y == keep && done == 0, "R8 y holds", y, keep);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        @(negedge clk);
        t_basic();
        t_extremes();
        t_random();
        t_busy_start();
        t_input_change();
        t_back_to_back();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule